// File: doc/BRIEF.md
# Delayed Sync Reference Generator

This block turns an external, asynchronous synchronization input into a single-cycle internal reference pulse. Each rising edge of the input starts a delay, and when the delay runs out the block pulses the reference to every channel whose enable bit is set. The delay is a fixed latency of 19 system-clock cycles plus twice the value of an 8-bit delay code. At the intended 25 MHz system clock that is 760 ns plus 80 ns per code step. The synchronizer latency counts toward the fixed part.

A second, purely combinational path selects one channel's clock and drives it back out as the synchronization output. The select bit picks channel A when set and channel C when clear. Channel timing generators, frequency multiplication and the register bus are outside the block. The delay code, enables and select arrive as plain inputs from the register file.

Top module: `syncRefGen`

## Requirements
- R1: While reset is asserted, and after reset is released with the sync input low, `chanRef` is 3'b000 and no pulse appears until a rising edge is seen.
- R2: Let E0 be the first rising clock edge at which `syncIn` is sampled high after being sampled low. With delay code N, the enabled bits of `chanRef` go high at edge E0 + 19 + 2·N and are low at the edge before.
- R3: Each reference pulse lasts exactly one clock cycle. Each accepted rising edge yields at most one pulse.
- R4: A new rising edge that arrives while a countdown is running restarts the countdown from the new edge. The earlier countdown produces no pulse.
- R5: A channel whose bit in `chanEnable` is 0 at the firing cycle gets no pulse. Bit 0 is channel A, bit 1 is channel B and bit 2 is channel C.
- R6: All enabled channels pulse in the same cycle, and the pulse pattern equals `chanEnable`.
- R7: `syncOut` equals `chanClk[0]` (channel A) when `outSrcSel` is 1 and `chanClk[2]` (channel C) when it is 0, with no clock delay.
- R8: A sync input held at a constant level, high or low, produces no further pulses. A falling edge produces none.
- R9: The full code range is honoured: N = 0 gives 19 cycles and N = 255 gives 529 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (25 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Raw asynchronous synchronization input |
| delayCode | input | 8 | Programmable delay, 2 cycles per step |
| chanEnable | input | 3 | Per-channel reference enable, bit 0 = A, bit 2 = C |
| outSrcSel | input | 1 | Sync output source, 1 = channel A, 0 = channel C |
| chanClk | input | 3 | Per-channel clocks, bit 0 = A, bit 2 = C |
| chanRef | output | 3 | Per-channel one-cycle reference pulses |
| syncOut | output | 1 | Selected channel clock driven out |

## Verification
The bench measures the exact firing edge for several delay codes, including both ends of the code range. An off-by-one in the synchronizer or the counter load would move the pulse one cycle early or late and fail the before/at/after samples. It re-triggers the input during a countdown; a design that let the first countdown finish would emit two pulses, and one that ignored the new edge would fire early. Long steady high levels and disabled channel masks catch a design that fires on level rather than edge, or that leaks pulses to gated channels. The output selector is swept in both polarities to catch swapped channels.

// File: rtl/syncRefPkg.sv
package syncRefPkg;

  typedef struct packed {
    logic load;  // rising edge seen: reload the countdown
    logic dec;   // countdown running, not yet expired
    logic fire;  // countdown expired: issue the reference
  } ctrlStrobe_t;

endpackage

// File: rtl/syncRefCtrl.sv
module syncRefCtrl
  import syncRefPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncIn,
  input  logic        cntZero,
  output ctrlStrobe_t strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic                   riseSeen;
  logic                   active;

  // Metastability chain, one flop per stage
  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= syncIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncChain[LAST];
  end

  assign riseSeen = syncChain[LAST] & ~syncPrev;

  always_comb begin
    strobe.load = riseSeen;
    strobe.fire = active & cntZero & ~riseSeen;
    strobe.dec  = active & ~cntZero & ~riseSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            active <= 1'b0;
    else if (strobe.load) active <= 1'b1;
    else if (strobe.fire) active <= 1'b0;
  end

  // R8: a level cannot produce back-to-back edge detections
  assert_no_double_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);

  // R4: after a detected edge the countdown is running
  assert_load_arms_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> active);

  // R3: one pulse per countdown, the next cycle cannot fire again
  assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> !strobe.fire);

endmodule

// File: rtl/syncRefDatapath.sv
module syncRefDatapath
  import syncRefPkg::*;
#(
  parameter int DELAY_W     = 8,
  parameter int NUM_CH      = 3,
  parameter int FIXED_CYC   = 19,
  parameter int STEP_CYC    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SEL1_CH     = 0,
  parameter int SEL0_CH     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DELAY_W-1:0] delayCode,
  input  logic [NUM_CH-1:0]  chanEnable,
  input  logic               outSrcSel,
  input  logic [NUM_CH-1:0]  chanClk,
  output logic               cntZero,
  output logic [NUM_CH-1:0]  chanRef,
  output logic               syncOut
);

  localparam int MAX_DELAY = FIXED_CYC + STEP_CYC * ((1 << DELAY_W) - 1);
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);
  // cycles already spent in the synchronizer and on the firing register
  localparam int BASE_LOAD = FIXED_CYC - SYNC_STAGES - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    loadVal = CNT_W'(BASE_LOAD) + CNT_W'(STEP_CYC) * CNT_W'(delayCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strobe.load) cnt <= loadVal;
    else if (strobe.dec)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ref
      always_ff @(posedge clk) begin
        if (!rstN) chanRef[c] <= 1'b0;
        else       chanRef[c] <= strobe.fire & chanEnable[c];
      end

      // R5: a channel only pulses when it was enabled at the firing cycle
      assert_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
        chanRef[c] |-> $past(chanEnable[c]));
    end
  endgenerate

  assign syncOut = outSrcSel ? chanClk[SEL1_CH] : chanClk[SEL0_CH];

  // R2: countdown steps by exactly one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |=> (cnt == $past(cnt) - 1'b1));

  // R4: reload takes the programmed value
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt == $past(loadVal)));

  // R3: pulses are one cycle wide
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|chanRef) |=> !(|chanRef));

  // R2: a pulse only follows an expired countdown
  assert_fire_expired_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|chanRef) |-> $past(cntZero));

endmodule

// File: rtl/syncRefGen.sv
module syncRefGen
  import syncRefPkg::*;
#(
  parameter int DELAY_W     = 8,
  parameter int NUM_CH      = 3,
  parameter int FIXED_CYC   = 19,
  parameter int STEP_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncIn,
  input  logic [DELAY_W-1:0] delayCode,
  input  logic [NUM_CH-1:0]  chanEnable,
  input  logic               outSrcSel,
  input  logic [NUM_CH-1:0]  chanClk,
  output logic [NUM_CH-1:0]  chanRef,
  output logic               syncOut
);

  ctrlStrobe_t strobe;
  logic        cntZero;

  syncRefCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .cntZero(cntZero),
    .strobe (strobe)
  );

  syncRefDatapath #(
    .DELAY_W    (DELAY_W),
    .NUM_CH     (NUM_CH),
    .FIXED_CYC  (FIXED_CYC),
    .STEP_CYC   (STEP_CYC),
    .SYNC_STAGES(SYNC_STAGES),
    .SEL1_CH    (0),
    .SEL0_CH    (NUM_CH - 1)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .delayCode (delayCode),
    .chanEnable(chanEnable),
    .outSrcSel (outSrcSel),
    .chanClk   (chanClk),
    .cntZero   (cntZero),
    .chanRef   (chanRef),
    .syncOut   (syncOut)
  );

  // R1: nothing leaves the block in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rstN) |-> (chanRef == '0));

endmodule

// File: tb/syncRefGen_bench.sv
module syncRefGen_bench;

  localparam int CLK_PERIOD = 40;
  localparam int NVEC = 6;
  // each entry: {delay code, enable mask}
  localparam logic [10:0] VEC [NVEC] = '{
    {8'd0,   3'b111},
    {8'd1,   3'b001},
    {8'd7,   3'b010},
    {8'd40,  3'b100},
    {8'd255, 3'b101},
    {8'd3,   3'b000}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic [7:0] delayCode = '0;
  logic [2:0] chanEnable = '0;
  logic       outSrcSel = 1'b0;
  logic [2:0] chanClk = '0;
  logic [2:0] chanRef;
  logic       syncOut;

  int checks = 0;
  int fails = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  syncRefGen u_syncRefGen (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .delayCode (delayCode),
    .chanEnable(chanEnable),
    .outSrcSel (outSrcSel),
    .chanClk   (chanClk),
    .chanRef   (chanRef),
    .syncOut   (syncOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (|chanRef) pulseCnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // call right after posedge E0; checks the edges around E0 + d
  task automatic expectPulse(input int d, input logic [2:0] en, input string req);
    repeat (d - 1) @(posedge clk);
    @(negedge clk);
    check(chanRef == 3'b000, {req, " before"}, chanRef, 0);
    @(negedge clk);
    check(chanRef == en, {req, " at edge"}, chanRef, en);
    @(negedge clk);
    check(chanRef == 3'b000, {req, " after"}, chanRef, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(chanRef == 3'b000, "R1 during reset", chanRef, 0);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    check(chanRef == 3'b000 && pulseCnt == 0, "R1 idle after reset", pulseCnt, 0);

    // table-driven delay and gating (R2 R5 R6 R9)
    for (int i = 0; i < NVEC; i++) begin
      delayCode  = VEC[i][10:3];
      chanEnable = VEC[i][2:0];
      base = pulseCnt;
      syncIn = 1'b1;
      @(posedge clk);
      expectPulse(19 + 2 * int'(VEC[i][10:3]), VEC[i][2:0], "R2 R5 R6 R9");
      syncIn = 1'b0;
      repeat (20) @(negedge clk);
      check(pulseCnt - base == ((VEC[i][2:0] != 0) ? 1 : 0), "R3 pulse count",
            pulseCnt - base, (VEC[i][2:0] != 0) ? 1 : 0);
    end

    // R4 restart during countdown
    delayCode = 8'd5; chanEnable = 3'b011;
    base = pulseCnt;
    syncIn = 1'b1;
    @(posedge clk);
    repeat (4) @(negedge clk);
    syncIn = 1'b0;
    repeat (5) @(negedge clk);
    syncIn = 1'b1;
    @(posedge clk);
    expectPulse(29, 3'b011, "R4 restart");
    syncIn = 1'b0;
    repeat (20) @(negedge clk);
    check(pulseCnt - base == 1, "R4 single pulse", pulseCnt - base, 1);

    // R8 long steady levels and falling edge
    delayCode = 8'd0; chanEnable = 3'b111;
    base = pulseCnt;
    syncIn = 1'b1;
    repeat (200) @(negedge clk);
    syncIn = 1'b0;
    repeat (200) @(negedge clk);
    check(pulseCnt - base == 1, "R8 level gives one pulse", pulseCnt - base, 1);

    // R7 output source selection
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 8; p++) begin
        outSrcSel = s[0];
        chanClk = p[2:0];
        #1;
        check(syncOut == (s[0] ? p[0] : p[2]), "R7 sync out select",
              syncOut, s[0] ? p[0] : p[2]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule